// File: doc/BRIEF.md
# PCI Configuration Address Generator

This block turns a configuration request (bus number, device/function number and an 8-bit register number) into the two values a local-bus-to-PCI bridge needs to run a configuration cycle. The first value is a 24-bit offset into a 16 MB configuration aperture. The second is a 16-bit value for the window's map register.

Requests on bus 0 target the segment directly attached to the bridge, so they become type 0 cycles. Requests on any other bus become type 1 cycles, which a downstream bridge forwards.

For type 0 cycles the device is chosen by a one-hot select line. The aperture offset only reaches address bit 23, so the select bit is split across two places:

- Slots 0 to 12 set an offset bit.
- Slots 13 to 20 set a bit in the upper byte of the map value.
- Higher slots cannot be encoded, and the request is flagged.

A one-cycle valid strobe launches each request. The results appear, registered, one cycle later together with a done pulse.

Top module: `cfgaddr_gen`

## Requirements
- R1: A request with bus number 0 yields a type 0 result: map bits 3:1 equal 3'b101, map bit 0 is 0 and the error flag is low for slots 0 to 20.
- R2: For a type 0 result, offset bits 7:0 equal the register number and offset bits 10:8 equal the function (devfn bits 2:0). Map bits 7:4 are always 0.
- R3: For type 0 with slot (devfn bits 7:3) from 0 to 12, offset bit slot+11 is the only select bit set, and map bits 15:8 are 0.
- R4: For type 0 with slot from 13 to 20, map bit slot-5 is the only select bit set, and offset bits 23:11 are 0.
- R5: For type 0 with slot from 21 to 31, the error flag is 1 and no select bit is set in either offset bits 23:11 or map bits 15:8. Function and register fields are still formed.
- R6: A request with a nonzero bus number yields offset = {bus, devfn, register} and map = 16'h000B (type 101, bit 0 set so that address bits 1:0 come from the host), with the error flag 0.
- R7: Outputs update at the clock edge that samples req_valid. cfg_done is high for exactly one cycle per valid cycle, including back-to-back requests.
- R8: Synchronous reset clears all outputs to 0. Without a valid request, offset, map and error hold their last values and cfg_done stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Slot in bits 7:3, function in bits 2:0 |
| req_reg | input | 8 | Configuration register number |
| cfg_offset | output | 24 | Offset inside the configuration aperture |
| cfg_map | output | 16 | Value for the window map register |
| cfg_err | output | 1 | Slot cannot be encoded for a type 0 cycle |
| cfg_done | output | 1 | One-cycle result strobe |

## Verification
The bench builds the block with its default parameters: a 24-bit offset, a 16-bit map value and select bits starting at map bit 8. These values place the low/high split between slots 12 and 13 and the error boundary between slots 20 and 21. All four edges (slots 12, 13, 20 and 21), plus slots 0 and 31, are driven on bus 0. Type 1 requests use buses 1 and 255, and back-to-back requests check that every valid cycle yields its own result.

// File: rtl/cfgaddr_pkg.sv
package cfgaddr_pkg;
  // PCI bus command code for a configuration access, placed in map bits 3:1
  localparam logic [2:0] CFG_CYCLE_CODE = 3'b101;

  typedef enum logic {
    CYC_LOCAL  = 1'b0,   // type 0: device on the attached segment
    CYC_REMOTE = 1'b1    // type 1: forwarded by a downstream bridge
  } cyc_kind_e;
endpackage

// File: rtl/cfgaddr_type0.sv
module cfgaddr_type0
  import cfgaddr_pkg::*;
#(
  parameter int OFS_W       = 24,
  parameter int MAP_W       = 16,
  parameter int REG_W       = 8,
  parameter int FN_W        = 3,
  parameter int SLOT_W      = 5,
  parameter int MAP_SEL_LSB = 8
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [FN_W-1:0]   fn,
  input  logic [REG_W-1:0]  regno,
  output logic [OFS_W-1:0]  ofs,
  output logic [MAP_W-1:0]  map,
  output logic              bad
);
  localparam int LOW_BASE = REG_W + FN_W;            // offset bit of slot 0
  localparam int LOW_MAX  = OFS_W - 1 - LOW_BASE;    // last slot in the offset
  localparam int HIGH_MAX = LOW_MAX + MAP_W - MAP_SEL_LSB; // last slot in the map

  always_comb begin
    ofs = '0;
    ofs[REG_W-1:0]     = regno;
    ofs[REG_W +: FN_W] = fn;
    for (int i = 0; i <= LOW_MAX; i++) begin
      if (int'(slot) == i) ofs[i + LOW_BASE] = 1'b1;
    end
  end

  always_comb begin
    map = '0;
    map[3:1] = CFG_CYCLE_CODE;
    map[0]   = 1'b0;   // address bits 1:0 forced to zero
    for (int i = LOW_MAX + 1; i <= HIGH_MAX; i++) begin
      if (int'(slot) == i) map[i - LOW_MAX - 1 + MAP_SEL_LSB] = 1'b1;
    end
  end

  assign bad = int'(slot) > HIGH_MAX;
endmodule

// File: rtl/cfgaddr_type1.sv
module cfgaddr_type1
  import cfgaddr_pkg::*;
#(
  parameter int OFS_W   = 24,
  parameter int MAP_W   = 16,
  parameter int BUS_W   = 8,
  parameter int DEVFN_W = 8,
  parameter int REG_W   = 8
) (
  input  logic [BUS_W-1:0]   bus,
  input  logic [DEVFN_W-1:0] devfn,
  input  logic [REG_W-1:0]   regno,
  output logic [OFS_W-1:0]   ofs,
  output logic [MAP_W-1:0]   map
);
  localparam int FIELD_W = BUS_W + DEVFN_W + REG_W;

  always_comb begin
    ofs = '0;
    ofs[FIELD_W-1:0] = {bus, devfn, regno};
    map = '0;
    map[3:1] = CFG_CYCLE_CODE;
    map[0]   = 1'b1;   // address bits 1:0 taken from the host
  end
endmodule

// File: rtl/cfgaddr_gen.sv
module cfgaddr_gen
  import cfgaddr_pkg::*;
#(
  parameter int OFS_W       = 24,
  parameter int MAP_W       = 16,
  parameter int BUS_W       = 8,
  parameter int DEVFN_W     = 8,
  parameter int REG_W       = 8,
  parameter int FN_W        = 3,
  parameter int MAP_SEL_LSB = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [BUS_W-1:0]   req_bus,
  input  logic [DEVFN_W-1:0] req_devfn,
  input  logic [REG_W-1:0]   req_reg,
  output logic [OFS_W-1:0]   cfg_offset,
  output logic [MAP_W-1:0]   cfg_map,
  output logic               cfg_err,
  output logic               cfg_done
);
  localparam int SLOT_W   = DEVFN_W - FN_W;
  localparam int LOW_BASE = REG_W + FN_W;

  cyc_kind_e           kind;
  logic [OFS_W-1:0]    t0_ofs, t1_ofs, nxt_ofs;
  logic [MAP_W-1:0]    t0_map, t1_map, nxt_map;
  logic                t0_bad, nxt_err;

  assign kind = (req_bus == '0) ? CYC_LOCAL : CYC_REMOTE;

  cfgaddr_type0 #(
    .OFS_W(OFS_W), .MAP_W(MAP_W), .REG_W(REG_W), .FN_W(FN_W),
    .SLOT_W(SLOT_W), .MAP_SEL_LSB(MAP_SEL_LSB)
  ) u_type0 (
    .slot (req_devfn[DEVFN_W-1:FN_W]),
    .fn   (req_devfn[FN_W-1:0]),
    .regno(req_reg),
    .ofs  (t0_ofs),
    .map  (t0_map),
    .bad  (t0_bad)
  );

  cfgaddr_type1 #(
    .OFS_W(OFS_W), .MAP_W(MAP_W), .BUS_W(BUS_W),
    .DEVFN_W(DEVFN_W), .REG_W(REG_W)
  ) u_type1 (
    .bus  (req_bus),
    .devfn(req_devfn),
    .regno(req_reg),
    .ofs  (t1_ofs),
    .map  (t1_map)
  );

  always_comb begin
    if (kind == CYC_LOCAL) begin
      nxt_ofs = t0_ofs;
      nxt_map = t0_map;
      nxt_err = t0_bad;
    end else begin
      nxt_ofs = t1_ofs;
      nxt_map = t1_map;
      nxt_err = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_offset <= '0;
      cfg_map    <= '0;
      cfg_err    <= 1'b0;
      cfg_done   <= 1'b0;
    end else begin
      cfg_done <= req_valid;
      if (req_valid) begin
        cfg_offset <= nxt_ofs;
        cfg_map    <= nxt_map;
        cfg_err    <= nxt_err;
      end
    end
  end

  // R7: one done per valid cycle
  a_r7_done_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> cfg_done);
  a_r7_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !cfg_done);

  // R8: results hold while idle
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(cfg_offset) && $stable(cfg_map) && $stable(cfg_err)));

  // R1: bus 0 selects the type 0 encoding
  a_r1_local_code: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_bus == '0) |=> (cfg_map[3:0] == 4'b1010));

  // R6: other buses select the type 1 encoding
  a_r6_remote_code: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_bus != '0) |=> (cfg_map == MAP_W'(16'h000B) && !cfg_err));

  // R3/R4: at most one select bit on a type 0 result
  a_r4_onehot_select: assert property (@(posedge clk) disable iff (rst)
    (cfg_done && !cfg_map[0]) |->
      $onehot0({cfg_offset[OFS_W-1:LOW_BASE], cfg_map[MAP_W-1:MAP_SEL_LSB]}));

  // R5: a flagged request carries no select bit
  a_r5_err_no_select: assert property (@(posedge clk) disable iff (rst)
    (cfg_done && cfg_err) |->
      ($countones({cfg_offset[OFS_W-1:LOW_BASE], cfg_map[MAP_W-1:MAP_SEL_LSB]}) == 0));
endmodule

// File: tb/cfgaddr_gen_tb_top.sv
module cfgaddr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [7:0]  req_bus, req_devfn, req_reg;
  logic [23:0] cfg_offset;
  logic [15:0] cfg_map;
  logic        cfg_err, cfg_done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic [23:0] ofs;
    logic [15:0] map;
    logic        err;
  } exp_t;

  exp_t sb_q[$];
  exp_t last_exp;

  always #5 clk = ~clk;

  cfgaddr_gen dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_bus(req_bus),
    .req_devfn(req_devfn), .req_reg(req_reg), .cfg_offset(cfg_offset),
    .cfg_map(cfg_map), .cfg_err(cfg_err), .cfg_done(cfg_done)
  );

  function automatic exp_t model(input logic [7:0] bus, input logic [7:0] devfn,
                                 input logic [7:0] regno);
    exp_t e;
    int slot;
    slot = int'(devfn[7:3]);
    if (bus != 8'd0) begin            // R6
      e.ofs = {bus, devfn, regno};
      e.map = 16'h000B;
      e.err = 1'b0;
    end else begin                    // R1, R2
      e.ofs = {13'd0, devfn[2:0], regno};
      e.map = 16'h000A;
      e.err = 1'b0;
      if (slot <= 12) e.ofs = e.ofs | (24'd1 << (slot + 11));      // R3
      else if (slot <= 20) e.map = e.map | (16'd1 << (slot - 5));  // R4
      else e.err = 1'b1;                                           // R5
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input exp_t act, input exp_t exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual ofs=%06h map=%04h err=%0b, expected ofs=%06h map=%04h err=%0b",
               req, act.ofs, act.map, act.err, exp.ofs, exp.map, exp.err);
    end
  endtask

  // Driver: one valid cycle per call, expected item pushed to the scoreboard
  task automatic send(input logic [7:0] bus, input logic [7:0] devfn,
                      input logic [7:0] regno, input bit keep);
    exp_t e;
    e = model(bus, devfn, regno);
    sb_q.push_back(e);
    last_exp  = e;
    req_valid = 1'b1;
    req_bus   = bus;
    req_devfn = devfn;
    req_reg   = regno;
    @(negedge clk);
    if (!keep) req_valid = 1'b0;
  endtask

  // Monitor: compare every done against the oldest expected item
  always @(negedge clk) begin
    exp_t act, e;
    #1;
    if (!rst && cfg_done) begin
      act = '{ofs: cfg_offset, map: cfg_map, err: cfg_err};
      if (sb_q.size() == 0) begin
        check(1'b0, "R7 unexpected done", act, act);
      end else begin
        e = sb_q.pop_front();
        check(act == e, "R1-R6 result (R1 R2 R3 R4 R5 R6)", act, e);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual running, expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    exp_t zero, act;
    zero = '0;
    rst = 1'b1; req_valid = 1'b0; req_bus = '0; req_devfn = '0; req_reg = '0;
    repeat (3) @(negedge clk);
    act = '{ofs: cfg_offset, map: cfg_map, err: cfg_err};
    check(act == zero && !cfg_done, "R8 reset state", act, zero);
    rst = 1'b0;
    @(negedge clk);

    // type 0, low slots (R3)
    send(8'd0, {5'd0, 3'd0}, 8'h00, 0);
    send(8'd0, {5'd5, 3'd3}, 8'h3C, 0);
    send(8'd0, {5'd12, 3'd7}, 8'hFF, 0);
    // type 0, high slots (R4)
    send(8'd0, {5'd13, 3'd1}, 8'h10, 0);
    send(8'd0, {5'd20, 3'd6}, 8'h04, 0);
    // type 0, out of range (R5)
    send(8'd0, {5'd21, 3'd2}, 8'h08, 0);
    send(8'd0, {5'd31, 3'd5}, 8'hA4, 0);
    // type 1 (R6)
    send(8'd1, 8'h00, 8'h00, 0);
    send(8'd255, 8'hFF, 8'hFC, 0);
    send(8'd7, {5'd13, 3'd4}, 8'h40, 0);
    @(negedge clk);

    // back-to-back requests (R7)
    send(8'd0, {5'd2, 3'd1}, 8'h14, 1);
    send(8'd3, {5'd25, 3'd0}, 8'h18, 1);
    send(8'd0, {5'd17, 3'd0}, 8'h1C, 0);
    @(negedge clk);

    // idle hold (R8): results keep last value, done stays low
    repeat (4) begin
      @(negedge clk);
      #2;
      act = '{ofs: cfg_offset, map: cfg_map, err: cfg_err};
      check(act == last_exp && !cfg_done, "R8 hold while idle", act, last_exp);
    end

    // everything consumed (R7)
    act = '0;
    check(sb_q.size() == 0, "R7 all requests answered", act, zero);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule